// File: doc/BRIEF.md
# Adaptive-Bandwidth Loop Filter Controller for a Digital PLL

This block is the loop-filter side of an all-digital phase-locked loop. It takes a reference and a feedback square wave, both already in the fast system clock domain. From them it derives a phase-error pulse, and it feeds an up/down modulus counter whose carry and borrow pulses step an increment/decrement oscillator. The counter's modulus sets the loop bandwidth. A small modulus gives frequent, coarse corrections. A large one gives rare, fine corrections.

The block measures how many system-clock cycles the two inputs disagree during each reference period. It compares that width against two programmable thresholds and places the loop in one of three regions: fast capture, slow capture or locked. Each region has its own power-of-two modulus. A wide error widens the bandwidth at once. Narrowing happens one region at a time and only after several quiet periods in a row, so the loop does not overshoot and then oscillate. A new modulus takes effect only when the counter wraps. The counter restarts at the middle of its range after every wrap.

Top module: `adpll_bw_ctrl`

## Requirements
- R1: A cycle with `ref_in` high and `fb_in` low counts the modulus counter up (feedback lags). A cycle with `fb_in` high and `ref_in` low counts it down. `phase_err` shows `ref_in ^ fb_in` one clock later.
- R2: The error width is the number of clock cycles in which the two inputs differ, counted from one rising edge of `ref_in` up to the next. The first rising edge after reset only starts the measurement and reports nothing.
- R3: The `region` encoding is 0 for fast capture, 1 for slow capture and 2 for locked. The value 3 never appears. Reported error widths are the only thing that changes the region.
- R4: A width above `thr_fast` moves the loop to fast capture after that single period. In the locked region, a width above `thr_lock` that is not above `thr_fast` moves it to slow capture at once.
- R5: The loop narrows by exactly one region only after 4 consecutive periods whose width qualifies for a narrower region. Any period that does not qualify clears the run.
- R6: A width equal to a threshold counts as not above it.
- R7: `locked` is high exactly while `region` is 2.
- R8: The modulus is 2^`k_exp`, with `k_exp` equal to 2, 4 or 6 for fast, slow and locked. A changed region is adopted only at a carry or borrow, or by reset.
- R9: `carry` is a one-cycle pulse issued when counting up from the top value. `borrow` is a one-cycle pulse issued when counting down from zero. After either pulse the count restarts at half the modulus then in force.
- R10: Reset gives region 0, `locked` low, `k_exp` 2, and `carry`, `borrow` and `phase_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave, synchronous to clk |
| fb_in | input | 1 | Divided oscillator feedback, synchronous to clk |
| thr_fast | input | 8 | Widths above this select fast capture |
| thr_lock | input | 8 | Widths above this (and not above thr_fast) select slow capture |
| phase_err | output | 1 | Registered phase-error pulse |
| carry | output | 1 | Increment pulse toward the oscillator |
| borrow | output | 1 | Decrement pulse toward the oscillator |
| region | output | 2 | Current bandwidth region |
| locked | output | 1 | High in the locked region |
| k_exp | output | 3 | Base-2 exponent of the modulus in force |

## Verification
The hardest state to reach is a region change with the modulus not yet reloaded. That needs the region to narrow while the counter sits still. The stimulus runs reference periods with the feedback exactly in phase, so the widths are zero and no counting happens. The loop then reaches slow capture with the fast modulus still in force. A constant lag is applied next, and the spacing of the carry pulses shows when the wider modulus took over. The broken run of quiet periods and the two threshold-equal widths come from a table of per-period feedback delays.

// File: rtl/adpll_bw_pkg.sv
package adpll_bw_pkg;

    typedef enum logic [1:0] {
        RG_FAST = 2'd0,
        RG_SLOW = 2'd1,
        RG_LOCK = 2'd2
    } region_e;

endpackage

// File: rtl/adpll_phase_meas.sv
// Phase comparison and per-period error-width measurement.
module adpll_phase_meas #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_in,
    input  logic         fb_in,
    output logic         up_o,
    output logic         dn_o,
    output logic         err_o,
    output logic         done_o,
    output logic [W-1:0] width_o
);

    typedef struct packed {
        logic         ref_d1;
        logic         armed;
        logic [W-1:0] acc;
        logic         up;
        logic         dn;
        logic         err;
        logic         done;
        logic [W-1:0] width;
    } pm_s;

    pm_s  s_d, s_q;
    logic err_now;
    logic rise;

    always_comb begin
        err_now  = ref_in ^ fb_in;
        rise     = ref_in & ~s_q.ref_d1;
        s_d      = s_q;
        s_d.ref_d1 = ref_in;
        s_d.up   = ref_in & ~fb_in;
        s_d.dn   = fb_in & ~ref_in;
        s_d.err  = err_now;
        s_d.done = 1'b0;
        if (rise) begin
            // a new period starts with this cycle
            s_d.armed = 1'b1;
            s_d.acc   = {{(W-1){1'b0}}, err_now};
            if (s_q.armed) begin
                s_d.done  = 1'b1;
                s_d.width = s_q.acc;
            end
        end else if (s_q.armed && err_now && (s_q.acc != {W{1'b1}})) begin
            s_d.acc = s_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign up_o    = s_q.up;
    assign dn_o    = s_q.dn;
    assign err_o   = s_q.err;
    assign done_o  = s_q.done;
    assign width_o = s_q.width;

endmodule

// File: rtl/adpll_region_fsm.sv
// Region selection with immediate widening and debounced narrowing.
module adpll_region_fsm
    import adpll_bw_pkg::*;
#(
    parameter int W        = 8,
    parameter int NARROW_N = 4,
    localparam int CW      = $clog2(NARROW_N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done_i,
    input  logic [W-1:0] width_i,
    input  logic [W-1:0] thr_fast,
    input  logic [W-1:0] thr_lock,
    output region_e      region_o,
    output logic         locked_o
);

    typedef struct packed {
        region_e       region;
        logic [CW-1:0] run;
        logic          locked;
    } rf_s;

    rf_s     s_d, s_q;
    region_e target;

    always_comb begin
        if (width_i > thr_fast)      target = RG_FAST;
        else if (width_i > thr_lock) target = RG_SLOW;
        else                         target = RG_LOCK;

        s_d = s_q;
        if (done_i) begin
            if (target < s_q.region) begin
                s_d.region = target;
                s_d.run    = '0;
            end else if (target > s_q.region) begin
                if (s_q.run == CW'(NARROW_N - 1)) begin
                    s_d.region = region_e'(s_q.region + 2'd1);
                    s_d.run    = '0;
                end else begin
                    s_d.run = s_q.run + 1'b1;
                end
            end else begin
                s_d.run = '0;
            end
        end
        s_d.locked = (s_d.region == RG_LOCK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.region <= RG_FAST;
            s_q.run    <= '0;
            s_q.locked <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign region_o = s_q.region;
    assign locked_o = s_q.locked;

endmodule

// File: rtl/adpll_kcounter.sv
// Up/down modulus counter; the modulus is reloaded only at a wrap.
module adpll_kcounter
    import adpll_bw_pkg::*;
#(
    parameter int KEXP_FAST = 2,
    parameter int KEXP_SLOW = 4,
    parameter int KEXP_LOCK = 6,
    localparam int KW       = KEXP_LOCK,
    localparam int EW       = $clog2(KEXP_LOCK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_i,
    input  logic          dn_i,
    input  region_e       region_i,
    output logic          carry_o,
    output logic          borrow_o,
    output logic [EW-1:0] kexp_o
);

    typedef struct packed {
        logic [EW-1:0] kexp;
        logic [KW-1:0] cnt;
        logic          carry;
        logic          borrow;
    } kc_s;

    kc_s           s_d, s_q;
    logic [EW-1:0] kexp_req;
    logic [KW:0]   pow;
    logic [KW-1:0] top;

    function automatic logic [KW-1:0] half_of(input logic [EW-1:0] e);
        logic [KW-1:0] v;
        v = '0;
        v[e - 1'b1] = 1'b1;
        return v;
    endfunction

    always_comb begin
        unique case (region_i)
            RG_SLOW: kexp_req = EW'(KEXP_SLOW);
            RG_LOCK: kexp_req = EW'(KEXP_LOCK);
            default: kexp_req = EW'(KEXP_FAST);
        endcase

        pow = '0;
        pow[s_q.kexp] = 1'b1;
        top = KW'(pow - 1'b1);

        s_d        = s_q;
        s_d.carry  = 1'b0;
        s_d.borrow = 1'b0;
        if (up_i && !dn_i) begin
            if (s_q.cnt == top) begin
                s_d.carry = 1'b1;
                s_d.kexp  = kexp_req;
                s_d.cnt   = half_of(kexp_req);
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (dn_i && !up_i) begin
            if (s_q.cnt == '0) begin
                s_d.borrow = 1'b1;
                s_d.kexp   = kexp_req;
                s_d.cnt    = half_of(kexp_req);
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.kexp   <= EW'(KEXP_FAST);
            s_q.cnt    <= half_of(EW'(KEXP_FAST));
            s_q.carry  <= 1'b0;
            s_q.borrow <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign carry_o  = s_q.carry;
    assign borrow_o = s_q.borrow;
    assign kexp_o   = s_q.kexp;

endmodule

// File: rtl/adpll_bw_ctrl.sv
// Adaptive-bandwidth loop filter controller: top level.
module adpll_bw_ctrl
    import adpll_bw_pkg::*;
#(
    parameter int W         = 8,
    parameter int NARROW_N  = 4,
    parameter int KEXP_FAST = 2,
    parameter int KEXP_SLOW = 4,
    parameter int KEXP_LOCK = 6,
    localparam int EW       = $clog2(KEXP_LOCK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic          fb_in,
    input  logic [W-1:0]  thr_fast,
    input  logic [W-1:0]  thr_lock,
    output logic          phase_err,
    output logic          carry,
    output logic          borrow,
    output logic [1:0]    region,
    output logic          locked,
    output logic [EW-1:0] k_exp
);

    logic         pd_up;
    logic         pd_dn;
    logic         pd_done;
    logic [W-1:0] pd_width;
    region_e      rg;

    adpll_phase_meas #(.W(W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .fb_in   (fb_in),
        .up_o    (pd_up),
        .dn_o    (pd_dn),
        .err_o   (phase_err),
        .done_o  (pd_done),
        .width_o (pd_width)
    );

    adpll_region_fsm #(.W(W), .NARROW_N(NARROW_N)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (pd_done),
        .width_i  (pd_width),
        .thr_fast (thr_fast),
        .thr_lock (thr_lock),
        .region_o (rg),
        .locked_o (locked)
    );

    adpll_kcounter #(
        .KEXP_FAST (KEXP_FAST),
        .KEXP_SLOW (KEXP_SLOW),
        .KEXP_LOCK (KEXP_LOCK)
    ) u_kcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (pd_up),
        .dn_i     (pd_dn),
        .region_i (rg),
        .carry_o  (carry),
        .borrow_o (borrow),
        .kexp_o   (k_exp)
    );

    assign region = rg;

endmodule

// File: rtl/adpll_bw_ctrl_chk.sv
module adpll_bw_ctrl_chk #(
    parameter int EW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          carry,
    input logic          borrow,
    input logic [1:0]    region,
    input logic          locked,
    input logic [EW-1:0] k_exp
);

    AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        region != 2'd3);                                                      // R3

    AST_NARROW_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (region > $past(region)) |-> (region == $past(region) + 2'd1));      // R5

    AST_LOCK_FROM_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(region) == 2'd1));                          // R7

    AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);                                                    // R9

    AST_BORROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |=> !borrow);                                                  // R9

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry && borrow));                                                  // R9

    AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(k_exp) |-> (carry || borrow));                               // R8

endmodule

bind adpll_bw_ctrl adpll_bw_ctrl_chk #(.EW(EW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .carry  (carry),
    .borrow (borrow),
    .region (region),
    .locked (locked),
    .k_exp  (k_exp)
);

// File: tb/sim_adpll_bw_ctrl.sv
module sim_adpll_bw_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [7:0] thr_fast = 8'd6;
    logic [7:0] thr_lock = 8'd2;
    logic       phase_err;
    logic       carry;
    logic       borrow;
    logic [1:0] region;
    logic       locked;
    logic [2:0] k_exp;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    adpll_bw_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .thr_fast(thr_fast), .thr_lock(thr_lock), .phase_err(phase_err),
        .carry(carry), .borrow(borrow), .region(region), .locked(locked),
        .k_exp(k_exp)
    );

    // {feedback delay d (error width 2d), region seen during this period}
    // thr_fast=6, thr_lock=2; region reflects all earlier periods.
    localparam logic [5:0] VEC [0:21] = '{
        {4'd2, 2'd0}, {4'd2, 2'd0}, {4'd2, 2'd0}, {4'd2, 2'd0},   // R5 run of 4
        {4'd4, 2'd1}, {4'd2, 2'd0},                               // R4 widen
        {4'd3, 2'd0}, {4'd3, 2'd0}, {4'd2, 2'd0}, {4'd1, 2'd1},   // R6 width 6
        {4'd1, 2'd1}, {4'd1, 2'd1}, {4'd2, 2'd1}, {4'd0, 2'd1},   // R5 run broken
        {4'd0, 2'd1}, {4'd1, 2'd1}, {4'd0, 2'd1}, {4'd0, 2'd2},   // R6 width 2
        {4'd3, 2'd2}, {4'd0, 2'd1}, {4'd4, 2'd1}, {4'd0, 2'd0}    // R4 from lock
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One 16-cycle reference period, feedback delayed by d cycles.
    task automatic run_period(input int d, input int exp_rg, input bit do_chk);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (do_chk && c == 4) begin
                chk(region == 2'(exp_rg), "R3/R4/R5/R6 region", region, exp_rg);
                chk(locked == (exp_rg == 2), "R7 locked", locked, exp_rg == 2);
            end
            ref_in = (c < 8);
            fb_in  = (c >= d) && (c < d + 8);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int nc;
        int nb;
        bit dbl;
        bit prev;

        // R10 reset state
        do_reset();
        @(negedge clk);
        chk(region == 2'd0, "R10 region", region, 0);
        chk(locked == 1'b0, "R10 locked", locked, 0);
        chk(k_exp == 3'd2, "R10 k_exp", k_exp, 2);
        chk(!carry && !borrow, "R10 carry/borrow", carry | borrow, 0);
        chk(phase_err == 1'b0, "R10 phase_err", phase_err, 0);

        // Region table (R2 first edge only arms)
        foreach (VEC[i]) run_period(int'(VEC[i][5:2]), int'(VEC[i][1:0]), 1'b1);

        // R1/R9 constant lag: up counting, K=4, carry every 2 cycles
        do_reset();
        @(negedge clk);
        ref_in = 1'b1; fb_in = 1'b0;
        nc = 0; nb = 0; dbl = 0; prev = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k == 0) chk(phase_err == 1'b1, "R1 phase_err", phase_err, 1);
            if (carry) nc++;
            if (borrow) nb++;
            if (carry && prev) dbl = 1;
            prev = carry;
        end
        chk(nc == 9, "R9 carry count", nc, 9);
        chk(nb == 0, "R1 no borrow when lagging", nb, 0);
        chk(!dbl, "R9 carry single cycle", dbl, 0);
        chk(region == 2'd0, "R2 first edge reports nothing", region, 0);

        // R1/R9 constant lead: down counting, borrow every 3 cycles
        do_reset();
        @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b1;
        nc = 0; nb = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k == 0) chk(phase_err == 1'b1, "R1 phase_err lead", phase_err, 1);
            if (carry) nc++;
            if (borrow) nb++;
        end
        chk(nb == 6, "R9 borrow count", nb, 6);
        chk(nc == 0, "R1 no carry when leading", nc, 0);

        // R8 region narrows with counter idle, modulus held until a wrap
        do_reset();
        for (int p = 0; p < 5; p++) run_period(0, 0, 1'b0);
        @(negedge clk);
        chk(region == 2'd1, "R5 slow after 4 quiet periods", region, 1);
        chk(k_exp == 3'd2, "R8 modulus held before wrap", k_exp, 2);
        ref_in = 1'b1; fb_in = 1'b0;
        nc = 0;
        for (int k = 0; k < 44; k++) begin
            @(negedge clk);
            if (carry) nc++;
        end
        chk(nc == 6, "R8 carries with reloaded modulus", nc, 6);
        chk(k_exp == 3'd4, "R8 k_exp after wrap", k_exp, 4);
        chk(region == 2'd1, "R3 region unchanged without edges", region, 1);

        // R10 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(region == 2'd0, "R10 region mid-run", region, 0);
        chk(k_exp == 3'd2, "R10 k_exp mid-run", k_exp, 2);
        chk(!locked && !carry, "R10 flags mid-run", locked | carry, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule